// File: doc/BRIEF.md
# Framed Serial DAC Write Controller

This block sends command words from a host to a serial digital-to-analog converter. A user accepts a word through a valid/ready handshake. The controller then plays out one framed transfer on four pins: an active-low chip select, a frame strobe, a serial clock and a serial data line. The frame strobe falls inside chip select, and it marks the start of the word. The word is shifted out most significant bit first. The converter samples each bit on a falling serial-clock edge. The controller changes the data line only on rising serial-clock edges.

Every edge comes from one sequencer running on the system clock. Each minimum interval in the converter's timing is a parameter counted in system-clock cycles, and each value is rounded up from the nanosecond figure. A parameter picks how the converter is told to latch the word. In one mode a final rising serial-clock edge is given and chip select then rises. In the other the frame strobe is raised early, together with that last rising clock edge. A single-cycle done pulse marks the end of each transfer. Ready is high only while the controller is idle, so a word offered during a transfer waits.

Top module: `sdac_frame_ctrl`

## Requirements
- R1: During and after reset, chip select and the frame strobe are high, the serial clock rests high, ready is high and done is low.
- R2: Each accepted word appears on the data line MSB first. The receiver sees exactly WORD_W falling serial-clock edges between the frame strobe falling and rising. A word sampled on those edges equals the accepted word.
- R3: Chip select is low for at least CS_FS_CYC cycles before the frame strobe falls.
- R4: The frame strobe is low, and the first data bit is driven, for at least max(FS_SCK_CYC, DAT_SU_CYC) cycles before the first falling serial-clock edge.
- R5: Within a frame, each serial-clock low phase lasts at least SCK_LO_CYC cycles and each high phase at least SCK_HI_CYC cycles. The data line never changes while the serial clock is low.
- R6: The data line is stable for at least DAT_SU_CYC cycles before each falling serial-clock edge. It holds for at least DAT_HD_CYC cycles after that edge.
- R7: At least LAST_FS_CYC cycles pass from the last falling serial-clock edge to the rise of the frame strobe.
- R8: With FS_UPDATE=0, the final rising serial-clock edge is followed END_CS_CYC cycles later by chip select and the frame strobe rising in the same cycle. With FS_UPDATE=1, the frame strobe rises in the same cycle as the final rising serial-clock edge, and chip select rises END_CS_CYC cycles later. In both modes chip select stays low for exactly CS_FS_CYC + max(FS_SCK_CYC,DAT_SU_CYC) + (WORD_W-1)·(max(SCK_LO_CYC,DAT_HD_CYC)+max(SCK_HI_CYC,DAT_SU_CYC)) + max(SCK_LO_CYC,DAT_HD_CYC,LAST_FS_CYC) + END_CS_CYC cycles.
- R9: The frame strobe stays high for at least FS_GAP_CYC cycles between two frames.
- R10: Ready is high only while idle, and it drops in the cycle after a word is accepted. A word offered while ready is low never produces a frame. Done is high for exactly one cycle per frame: the first cycle in which chip select is high again.
- R11: The frame strobe is low only while chip select is low, and the serial clock is high whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | Controller is idle and takes the offered word |
| in_word | input | WORD_W (16) | Command word to send |
| done | output | 1 | One-cycle pulse when a transfer completes |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_fs | output | 1 | Frame strobe, falls to open a frame |
| dac_sclk | output | 1 | Serial clock, rests high |
| dac_sdo | output | 1 | Serial data, MSB first |

## Verification
All pins are registered, so each one changes on a rising system-clock edge. The bench samples on the falling edge, which lets it count every interval in whole cycles, from the sample where one pin changed to the sample where another changed. Chip select falls in the cycle after the accepting edge, and ready is already low in that first sampled cycle. The received word and the done pulse are due in the very sample where chip select is first seen high again. There the bench compares the word against the head of its expected queue, and the chip-select low length against the closed-form count in R8. Both update modes run side by side on identical stimulus: random words, random gaps including back-to-back offers, directed edge patterns, and an offer made in the middle of a transfer.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CSSU,
      ST_FSSU,
      ST_LO,
      ST_HI,
      ST_END,
      ST_GAP
   } sdac_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdac_wait_timer.sv
module sdac_wait_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdac_word_shifter.sv
module sdac_word_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              advance,
   output logic              sdo,
   output logic              last_bit
);

   localparam int RW = $clog2(WORD_W + 1);

   logic [WORD_W-1:0] shreg_q;
   logic [RW-1:0]     left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         left_q  <= '0;
      end else if (load) begin
         shreg_q <= load_word;
         left_q  <= RW'(WORD_W);
      end else if (advance) begin
         shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
         left_q  <= (left_q != '0) ? left_q - 1'b1 : left_q;
      end
   end

   assign sdo      = shreg_q[WORD_W-1];
   assign last_bit = (left_q == RW'(1));

endmodule

// File: rtl/sdac_frame_seq.sv
module sdac_frame_seq
   import sdac_pkg::*;
#(
   parameter int CNT_W     = 4,
   parameter int T_CS      = 3,
   parameter int T_FS      = 2,
   parameter int T_LO      = 7,
   parameter int T_HI      = 7,
   parameter int T_LAST    = 7,
   parameter int T_END     = 3,
   parameter int T_GAP     = 5,
   parameter bit FS_UPDATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             last_bit,
   input  logic             tmr_expired,
   output logic             in_ready,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             sh_load,
   output logic             sh_adv,
   output logic             done,
   output logic             cs_n,
   output logic             fs,
   output logic             sclk
);

   localparam logic [CNT_W-1:0] V_CS   = CNT_W'(T_CS - 1);
   localparam logic [CNT_W-1:0] V_FS   = CNT_W'(T_FS - 1);
   localparam logic [CNT_W-1:0] V_LO   = CNT_W'(T_LO - 1);
   localparam logic [CNT_W-1:0] V_HI   = CNT_W'(T_HI - 1);
   localparam logic [CNT_W-1:0] V_LAST = CNT_W'(T_LAST - 1);
   localparam logic [CNT_W-1:0] V_END  = CNT_W'(T_END - 1);
   localparam logic [CNT_W-1:0] V_GAP  = CNT_W'(T_GAP - 1);

   sdac_state_e st_q, st_d;
   logic        end_fs_hi;

   generate
      if (FS_UPDATE) begin : g_fs_latch
         assign end_fs_hi = 1'b1;
      end else begin : g_edge_latch
         assign end_fs_hi = 1'b0;
      end
   endgenerate

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_adv   = 1'b0;
      unique case (st_q)
         ST_IDLE: if (in_valid) begin
            st_d     = ST_CSSU;
            tmr_load = 1'b1;
            tmr_val  = V_CS;
            sh_load  = 1'b1;
         end
         ST_CSSU: if (tmr_expired) begin
            st_d     = ST_FSSU;
            tmr_load = 1'b1;
            tmr_val  = V_FS;
         end
         ST_FSSU: if (tmr_expired) begin
            st_d     = ST_LO;
            tmr_load = 1'b1;
            tmr_val  = last_bit ? V_LAST : V_LO;
         end
         ST_LO: if (tmr_expired) begin
            sh_adv   = 1'b1;
            tmr_load = 1'b1;
            if (last_bit) begin
               st_d    = ST_END;
               tmr_val = V_END;
            end else begin
               st_d    = ST_HI;
               tmr_val = V_HI;
            end
         end
         ST_HI: if (tmr_expired) begin
            st_d     = ST_LO;
            tmr_load = 1'b1;
            tmr_val  = last_bit ? V_LAST : V_LO;
         end
         ST_END: if (tmr_expired) begin
            st_d     = ST_GAP;
            tmr_load = 1'b1;
            tmr_val  = V_GAP;
         end
         ST_GAP: if (tmr_expired) begin
            st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         cs_n <= 1'b1;
         fs   <= 1'b1;
         sclk <= 1'b1;
         done <= 1'b0;
      end else begin
         st_q <= st_d;
         cs_n <= !(st_d inside {ST_CSSU, ST_FSSU, ST_LO, ST_HI, ST_END});
         fs   <= !((st_d inside {ST_FSSU, ST_LO, ST_HI}) ||
                   ((st_d == ST_END) && !end_fs_hi));
         sclk <= (st_d != ST_LO);
         done <= (st_d == ST_GAP) && (st_q != ST_GAP);
      end
   end

   assign in_ready = (st_q == ST_IDLE);

endmodule

// File: rtl/sdac_frame_ctrl.sv
module sdac_frame_ctrl
   import sdac_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int CS_FS_CYC   = 3,
   parameter int FS_SCK_CYC  = 2,
   parameter int SCK_HI_CYC  = 7,
   parameter int SCK_LO_CYC  = 7,
   parameter int DAT_SU_CYC  = 2,
   parameter int DAT_HD_CYC  = 2,
   parameter int LAST_FS_CYC = 3,
   parameter int END_CS_CYC  = 3,
   parameter int FS_GAP_CYC  = 5,
   parameter bit FS_UPDATE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   output logic              done,
   output logic              dac_cs_n,
   output logic              dac_fs,
   output logic              dac_sclk,
   output logic              dac_sdo
);

   localparam int T_CS   = CS_FS_CYC;
   localparam int T_FS   = imax(FS_SCK_CYC, DAT_SU_CYC);
   localparam int T_LO   = imax(SCK_LO_CYC, DAT_HD_CYC);
   localparam int T_HI   = imax(SCK_HI_CYC, DAT_SU_CYC);
   localparam int T_LAST = imax(T_LO, LAST_FS_CYC);
   localparam int T_END  = END_CS_CYC;
   localparam int T_GAP  = FS_GAP_CYC;
   localparam int T_MAX  = imax(imax(imax(T_CS, T_FS), imax(T_HI, T_LAST)),
                                imax(T_END, T_GAP));
   localparam int CNT_W  = imax(1, $clog2(T_MAX + 1));

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("sdac_frame_ctrl: WORD_W must be at least 2");
      end
      if (CS_FS_CYC < 1 || FS_SCK_CYC < 1 || SCK_HI_CYC < 1 || SCK_LO_CYC < 1 ||
          DAT_SU_CYC < 1 || DAT_HD_CYC < 1 || LAST_FS_CYC < 1 ||
          END_CS_CYC < 1 || FS_GAP_CYC < 1) begin : g_bad_timing
         $error("sdac_frame_ctrl: every interval needs at least one cycle");
      end
   endgenerate

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   logic             sh_load;
   logic             sh_adv;
   logic             last_bit;

   sdac_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sdac_word_shifter #(.WORD_W(WORD_W)) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sh_load),
      .load_word (in_word),
      .advance   (sh_adv),
      .sdo       (dac_sdo),
      .last_bit  (last_bit)
   );

   sdac_frame_seq #(
      .CNT_W     (CNT_W),
      .T_CS      (T_CS),
      .T_FS      (T_FS),
      .T_LO      (T_LO),
      .T_HI      (T_HI),
      .T_LAST    (T_LAST),
      .T_END     (T_END),
      .T_GAP     (T_GAP),
      .FS_UPDATE (FS_UPDATE)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .last_bit    (last_bit),
      .tmr_expired (tmr_expired),
      .in_ready    (in_ready),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .sh_load     (sh_load),
      .sh_adv      (sh_adv),
      .done        (done),
      .cs_n        (dac_cs_n),
      .fs          (dac_fs),
      .sclk        (dac_sclk)
   );

endmodule

// File: rtl/sdac_frame_chk.sv
module sdac_frame_chk #(
   parameter int SCK_LO_CYC = 7,
   parameter bit FS_UPDATE  = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic done,
   input logic cs_n,
   input logic fs,
   input logic sclk,
   input logic sdo
);

   int lo_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_run <= 0;
      end else if (sclk) begin
         lo_run <= 0;
      end else if (lo_run < 1048576) begin
         lo_run <= lo_run + 1;
      end
   end

   AST_IDLE_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (cs_n && fs && sclk)); // R10
   AST_FS_NESTED_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !fs |-> !cs_n); // R11
   AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk); // R11
   AST_DONE_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !$past(cs_n))); // R10
   AST_SDO_STILL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk && !$past(sclk)) |-> $stable(sdo)); // R5
   AST_SCLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && !$past(sclk)) |-> (lo_run >= SCK_LO_CYC)); // R5
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready); // R10

   generate
      if (FS_UPDATE) begin : g_fs_mode
         AST_FS_RISES_WITH_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fs) |-> ($rose(sclk) && !cs_n)); // R8
      end else begin : g_edge_mode
         AST_FS_RISES_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fs) |-> $rose(cs_n)); // R8
      end
   endgenerate

endmodule

bind sdac_frame_ctrl sdac_frame_chk #(
   .SCK_LO_CYC (SCK_LO_CYC),
   .FS_UPDATE  (FS_UPDATE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .done     (done),
   .cs_n     (dac_cs_n),
   .fs       (dac_fs),
   .sclk     (dac_sclk),
   .sdo      (dac_sdo)
);

// File: tb/sdac_frame_ctrl_bench.sv
`timescale 1ns/1ps

module sdac_frame_mon #(
   parameter int WORD_W      = 16,
   parameter int CS_FS_CYC   = 3,
   parameter int FS_SCK_CYC  = 2,
   parameter int SCK_HI_CYC  = 7,
   parameter int SCK_LO_CYC  = 7,
   parameter int DAT_SU_CYC  = 2,
   parameter int DAT_HD_CYC  = 2,
   parameter int LAST_FS_CYC = 3,
   parameter int END_CS_CYC  = 3,
   parameter int FS_GAP_CYC  = 5,
   parameter bit FS_UPDATE   = 1'b0
) (
   input  logic              clk,
   input  logic              cs_n,
   input  logic              fs,
   input  logic              sclk,
   input  logic              sdo,
   input  logic              done,
   input  logic [WORD_W-1:0] exp_word,
   output int                n_chk,
   output int                n_fail,
   output logic              pop
);

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int T_FS   = mx(FS_SCK_CYC, DAT_SU_CYC);
   localparam int T_LO   = mx(SCK_LO_CYC, DAT_HD_CYC);
   localparam int T_HI   = mx(SCK_HI_CYC, DAT_SU_CYC);
   localparam int T_LAST = mx(T_LO, LAST_FS_CYC);
   localparam int CS_LEN = CS_FS_CYC + T_FS + (WORD_W - 1) * (T_LO + T_HI) + T_LAST + END_CS_CYC;

   int cyc = 0;
   int t_csf = -100000, t_fsf = -100000, t_fsr = -100000;
   int t_fall = -100000, t_rise = -100000, t_sdo = -100000;
   int nbits = 0;
   logic [WORD_W-1:0] word = '0;
   logic p_cs = 1'b1, p_fs = 1'b1, p_sclk = 1'b1, p_sdo = 1'b0;

   initial begin
      n_chk = 0;
      n_fail = 0;
      pop = 1'b0;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s (mode %0d) at sample %0d: actual %0d expected %0d",
                  tag, FS_UPDATE, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      pop = 1'b0;
      if (sdo != p_sdo) begin
         if (!cs_n && !sclk) chk(1'b0, "R5 data moved while clock low", 1, 0);
         if (!cs_n && nbits > 0) chk(cyc - t_fall >= DAT_HD_CYC, "R6 hold", cyc - t_fall, DAT_HD_CYC);
         t_sdo = cyc;
      end
      if (!cs_n && p_cs) begin
         chk(fs, "R11 strobe high at select", fs, 1);
         t_csf = cyc;
      end
      if (!fs && p_fs) begin
         chk(!cs_n, "R11 strobe inside select", cs_n, 0);
         chk(cyc - t_csf >= CS_FS_CYC, "R3 select to strobe", cyc - t_csf, CS_FS_CYC);
         chk(cyc - t_fsr >= FS_GAP_CYC, "R9 strobe high gap", cyc - t_fsr, FS_GAP_CYC);
         nbits = 0;
         word = '0;
         t_fsf = cyc;
      end
      if (!sclk && p_sclk && !cs_n) begin
         if (nbits == 0) begin
            chk(cyc - t_fsf >= T_FS, "R4 strobe to first fall", cyc - t_fsf, T_FS);
         end else begin
            chk(cyc - t_rise >= SCK_HI_CYC, "R5 high width", cyc - t_rise, SCK_HI_CYC);
         end
         chk(cyc - t_sdo >= DAT_SU_CYC, "R6 setup", cyc - t_sdo, DAT_SU_CYC);
         word = {word[WORD_W-2:0], sdo};
         nbits++;
         t_fall = cyc;
      end
      if (sclk && !p_sclk && !cs_n) begin
         chk(cyc - t_fall >= SCK_LO_CYC, "R5 low width", cyc - t_fall, SCK_LO_CYC);
         t_rise = cyc;
      end
      if (fs && !p_fs) begin
         chk(nbits == WORD_W, "R2 falling edges per frame", nbits, WORD_W);
         chk(cyc - t_fall >= LAST_FS_CYC, "R7 last fall to strobe", cyc - t_fall, LAST_FS_CYC);
         if (FS_UPDATE) chk(sclk && !p_sclk && !cs_n, "R8 strobe with last rise", sclk, 1);
         else           chk(cs_n && !p_cs, "R8 strobe with select", cs_n, 1);
         t_fsr = cyc;
      end
      if (cs_n && !p_cs) begin
         chk(word == exp_word, "R2 received word", int'(word), int'(exp_word));
         chk(cyc - t_csf == CS_LEN, "R8 select low length", cyc - t_csf, CS_LEN);
         if (FS_UPDATE) chk(cyc - t_fsr >= END_CS_CYC, "R8 strobe to select", cyc - t_fsr, END_CS_CYC);
         else           chk(cyc - t_rise >= END_CS_CYC, "R8 last rise to select", cyc - t_rise, END_CS_CYC);
         chk(done, "R10 done with select rise", done, 1);
         pop = 1'b1;
      end else if (done) begin
         chk(1'b0, "R10 stray done", 1, 0);
      end
      if (cs_n && !sclk) chk(1'b0, "R11 clock low outside frame", 0, 1);
      if (cs_n && !fs)   chk(1'b0, "R11 strobe low outside select", 0, 1);
      p_cs = cs_n;
      p_fs = fs;
      p_sclk = sclk;
      p_sdo = sdo;
   end

endmodule

module sdac_frame_ctrl_bench;

   localparam int WORD_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [WORD_W-1:0] in_word = '0;
   logic rdy0, rdy1, done0, done1;
   logic cs0, fs0, sck0, sdo0, cs1, fs1, sck1, sdo1;
   logic [WORD_W-1:0] head0 = '0, head1 = '0;
   logic pop0, pop1;
   int mchk0, mfail0, mchk1, mfail1;
   int n_chk = 0, n_fail = 0;
   int sent = 0, dn0 = 0, dn1 = 0;
   bit finished = 1'b0;
   logic [WORD_W-1:0] exp0[$];
   logic [WORD_W-1:0] exp1[$];

   always #2 clk = ~clk;

   sdac_frame_ctrl #(.WORD_W(WORD_W), .FS_UPDATE(1'b0)) u_sdac_frame_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0), .in_word(in_word),
      .done(done0), .dac_cs_n(cs0), .dac_fs(fs0), .dac_sclk(sck0), .dac_sdo(sdo0));

   sdac_frame_ctrl #(.WORD_W(WORD_W), .FS_UPDATE(1'b1)) u_sdac_frame_ctrl_fs (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1), .in_word(in_word),
      .done(done1), .dac_cs_n(cs1), .dac_fs(fs1), .dac_sclk(sck1), .dac_sdo(sdo1));

   sdac_frame_mon #(.WORD_W(WORD_W), .FS_UPDATE(1'b0)) u_mon0 (
      .clk(clk), .cs_n(cs0), .fs(fs0), .sclk(sck0), .sdo(sdo0), .done(done0),
      .exp_word(head0), .n_chk(mchk0), .n_fail(mfail0), .pop(pop0));

   sdac_frame_mon #(.WORD_W(WORD_W), .FS_UPDATE(1'b1)) u_mon1 (
      .clk(clk), .cs_n(cs1), .fs(fs1), .sclk(sck1), .sdo(sdo1), .done(done1),
      .exp_word(head1), .n_chk(mchk1), .n_fail(mfail1), .pop(pop1));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (pop0) begin
         if (exp0.size() == 0) chk(1'b0, "R2 unexpected frame (edge mode)", 1, 0);
         else void'(exp0.pop_front());
      end
      if (pop1) begin
         if (exp1.size() == 0) chk(1'b0, "R2 unexpected frame (strobe mode)", 1, 0);
         else void'(exp1.pop_front());
      end
      head0 <= (exp0.size() > 0) ? exp0[0] : '0;
      head1 <= (exp1.size() > 0) ? exp1[0] : '0;
   end

   always @(negedge clk) begin
      if (done0) dn0++;
      if (done1) dn1++;
   end

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_chk + mchk0 + mchk1, n_fail + mfail0 + mfail1);
      $finish;
   endtask

   task automatic send(input logic [WORD_W-1:0] w);
      in_word = w;
      in_valid = 1'b1;
      forever begin
         if (rdy0) begin
            exp0.push_back(w);
            exp1.push_back(w);
            sent++;
            @(negedge clk);
            in_valid = 1'b0;
            chk(!rdy0 && !rdy1, "R10 ready low after accept", rdy0 | rdy1, 0);
            break;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
         summary();
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(cs0 && fs0 && sck0 && cs1 && fs1 && sck1, "R1 pins in reset", {cs0, fs0, sck0}, 7);
      chk(!done0 && !done1, "R1 done in reset", done0 | done1, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(rdy0 && rdy1, "R1 ready after reset", rdy0 & rdy1, 1);
      chk(cs0 && fs0 && sck0 && !done0, "R1 idle pins after reset", {cs0, fs0, sck0, done0}, 14);

      // directed patterns: edges of the word space, alternating bits, single bits
      send(16'h0000);
      send(16'hFFFF);
      send(16'h8000);
      send(16'h0001);
      repeat (3) @(negedge clk);
      send(16'hAAAA);
      send(16'h5555);

      // offer a word while busy: must be refused and never framed (R10)
      repeat (20) @(negedge clk);
      in_word = 16'h1234;
      in_valid = 1'b1;
      for (int i = 0; i < 10; i++) begin
         chk(!rdy0 && !rdy1, "R10 ready low mid-transfer", rdy0 | rdy1, 0);
         @(negedge clk);
      end
      in_valid = 1'b0;

      // random words with random gaps, including back-to-back offers
      for (int n = 0; n < 40; n++) begin
         send(WORD_W'($urandom));
         repeat ($urandom_range(3, 0)) @(negedge clk);
      end

      for (int i = 0; i < 2000 && (exp0.size() != 0 || exp1.size() != 0); i++) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(exp0.size() == 0, "R2 all words framed (edge mode)", exp0.size(), 0);
      chk(exp1.size() == 0, "R2 all words framed (strobe mode)", exp1.size(), 0);
      chk(dn0 == sent, "R10 done count (edge mode)", dn0, sent);
      chk(dn1 == sent, "R10 done count (strobe mode)", dn1, sent);
      chk(rdy0 && cs0 && fs0 && sck0, "R1 back to idle", {rdy0, cs0, fs0, sck0}, 15);
      finished = 1'b1;
      summary();
   end

endmodule